// File: doc/BRIEF.md
# Infoframe Packet Slot Scheduler

This block holds a small bank of auxiliary-packet slots for a video transmitter and decides when each one goes out. Software fills every slot through a 32-bit register bus with one header word (packet type, version, length) and seven payload words. It then gives the slot a repeat policy in a shared configuration register. The policy is one of off, send once, send on every video field, or send on every video frame.

The block watches the field-start and frame-start strobes of the video timing path and marks slots as pending. While any slot is pending and the packet path is idle, it raises a request. On a grant it streams one packet on a byte-wide output: three header bytes, then the 28 payload bytes. Payload bytes are unpacked little-endian from the 32-bit words, so the first payload byte, the checksum, is bits [7:0] of payload word 0.

The sequencer has three states. `ST_IDLE` holds until a grant arrives with a pending slot and then moves to `ST_HEAD`. `ST_HEAD` sends the three header bytes and then moves to `ST_BODY`. `ST_BODY` sends the payload bytes and returns to `ST_IDLE` after the last one.

Top module: `infoframe_slot_sched`

## Requirements
- R1: After reset every slot mode is off, the configuration register reads 0, `pkt_req` is low and `pkt_valid` is low.
- R2: Slot s (0-based) has its header at 0x100 + 0x40*s and payload word w (0..6) at header + 4 + 4*w. The configuration register is at 0x000. The header reads back only bits [19:0] of the written word. Payload words read back whole. Slot s mode sits in configuration bits [4s+1:4s], and the upper two bits of each nibble always read 0.
- R3: A packet has 31 consecutive `pkt_valid` cycles. The bytes, in order, are header bits [7:0], header bits [15:8] and {4'b0, header bits [19:16]}, then the payload bytes, word 0 first and within each word bits [7:0] first. `pkt_first` marks the first byte, `pkt_last` marks the last byte, and `pkt_slot` gives the slot number.
- R4: The first byte appears in the cycle after the clock edge that samples `pkt_req` and `pkt_gnt` both high.
- R5: Mode 0 (off) raises no request on any strobe. Writing mode 0 to a pending slot withdraws its request at once.
- R6: Mode 1 (once) becomes pending on the next frame strobe only, not on a field strobe. After its packet ends, the hardware clears the mode to 0 and the cleared value reads back as 0.
- R7: Mode 2 (field) becomes pending on field strobes only. Mode 3 (frame) becomes pending on frame strobes only.
- R8: Several strobes that arrive before a slot is granted produce a single packet.
- R9: When several slots are pending, the lowest slot number is served first, with one packet per grant.
- R10: A nonzero mode written to the slot being sent reads back as the old mode until the packet ends, and then takes effect.
- R11: A strobe that falls in the grant cycle of its own slot leaves that slot pending again, so a second packet follows.
- R12: `pkt_req` stays low while a packet is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| field_stb | input | 1 | One-cycle field-start pulse |
| frame_stb | input | 1 | One-cycle frame-start pulse |
| pkt_req | output | 1 | A slot is pending and the packet path is idle |
| pkt_gnt | input | 1 | Grant from the packet consumer |
| pkt_valid | output | 1 | `pkt_byte` carries a packet byte |
| pkt_first | output | 1 | First byte of a packet |
| pkt_last | output | 1 | Last byte of a packet |
| pkt_slot | output | SLOT_W | Slot being sent |
| pkt_byte | output | 8 | Packet byte |

## Verification
Two functions can fall in the same cycle, and both are provoked on purpose.

The first is a frame strobe that coincides with the grant of its own frame-mode slot. The bench raises `frame_stb` and `pkt_gnt` in the same cycle. It passes only if a second full packet for that slot follows the first.

The second is a configuration write that lands on the slot currently being sent. The bench writes a new nonzero mode partway through a packet. It judges the result by the readback, which must show the old mode during the packet and the new mode once `pkt_last` has passed. It also checks that the re-armed one-shot mode is then served and cleared.

// File: rtl/ifs_pkg.sv
package ifs_pkg;

    // Repeat policy held in the low two bits of each slot nibble
    localparam logic [1:0] MODE_OFF   = 2'd0;
    localparam logic [1:0] MODE_ONCE  = 2'd1;
    localparam logic [1:0] MODE_FIELD = 2'd2;
    localparam logic [1:0] MODE_FRAME = 2'd3;

    // Header bytes: type, version, length nibble
    localparam int HDR_BYTES = 3;
    localparam int HDR_BITS  = 20;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_BODY = 2'd2
    } tx_state_e;

endpackage

// File: rtl/ifs_slot_regs.sv
module ifs_slot_regs
    import ifs_pkg::*;
#(
    parameter int NUM_SLOTS     = 4,
    parameter int PAYLOAD_WORDS = 7,
    parameter int ADDR_W        = 12,
    parameter int SLOT_BASE     = 'h100,
    parameter int SLOT_STRIDE   = 'h40
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           wr_en,
    input  logic [ADDR_W-1:0]                              addr,
    input  logic [31:0]                                    wdata,
    output logic [NUM_SLOTS-1:0][HDR_BITS-1:0]             hdr,
    output logic [NUM_SLOTS-1:0][PAYLOAD_WORDS-1:0][31:0]  pay,
    output logic [31:0]                                    rd_data
);

    localparam int WIN_WORDS = PAYLOAD_WORDS + 1;

    logic [NUM_SLOTS-1:0][WIN_WORDS-1:0][31:0] rd_part;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        for (genvar w = 0; w < WIN_WORDS; w++) begin : g_word
            localparam logic [ADDR_W-1:0] WORD_ADDR =
                ADDR_W'(SLOT_BASE + s * SLOT_STRIDE + 4 * w);
            logic hit;
            assign hit = (addr == WORD_ADDR);

            if (w == 0) begin : g_hdr
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        hdr[s] <= '0;
                    else if (wr_en && hit)
                        hdr[s] <= wdata[HDR_BITS-1:0];
                end
                assign rd_part[s][w] = hit ? {{(32-HDR_BITS){1'b0}}, hdr[s]} : 32'd0;
            end else begin : g_pay
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        pay[s][w-1] <= '0;
                    else if (wr_en && hit)
                        pay[s][w-1] <= wdata;
                end
                assign rd_part[s][w] = hit ? pay[s][w-1] : 32'd0;
            end
        end
    end

    always_comb begin
        rd_data = 32'd0;
        for (int s = 0; s < NUM_SLOTS; s++)
            for (int w = 0; w < WIN_WORDS; w++)
                rd_data = rd_data | rd_part[s][w];
    end

endmodule

// File: rtl/ifs_byte_pick.sv
module ifs_byte_pick
    import ifs_pkg::*;
#(
    parameter int NUM_SLOTS     = 4,
    parameter int PAYLOAD_WORDS = 7,
    parameter int SLOT_W        = 2,
    parameter int BYTE_W        = 5
) (
    input  logic [NUM_SLOTS-1:0][HDR_BITS-1:0]             hdr,
    input  logic [NUM_SLOTS-1:0][PAYLOAD_WORDS-1:0][31:0]  pay,
    input  logic [SLOT_W-1:0]                              slot,
    input  logic [BYTE_W-1:0]                              idx,
    output logic [7:0]                                     byte_out
);

    logic [HDR_BITS-1:0] hsel;
    logic [BYTE_W-1:0]   pidx;
    logic [31:0]         wsel;

    always_comb begin
        hsel = hdr[slot];
        pidx = idx - BYTE_W'(HDR_BYTES);
        wsel = pay[slot][pidx[BYTE_W-1:2]];
        if (idx < BYTE_W'(HDR_BYTES)) begin
            unique case (idx[1:0])
                2'd0:    byte_out = hsel[7:0];
                2'd1:    byte_out = hsel[15:8];
                default: byte_out = {4'b0, hsel[19:16]};
            endcase
        end else begin
            byte_out = wsel[pidx[1:0]*8 +: 8];
        end
    end

endmodule

// File: rtl/ifs_sched.sv
module ifs_sched
    import ifs_pkg::*;
#(
    parameter int NUM_SLOTS     = 4,
    parameter int PAYLOAD_WORDS = 7,
    parameter int SLOT_W        = 2,
    parameter int BYTE_W        = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [NUM_SLOTS-1:0][1:0]     cfg_mode,
    output logic [31:0]                   cfg_rdata,
    input  logic                          field_stb,
    input  logic                          frame_stb,
    input  logic                          pkt_gnt,
    output logic                          pkt_req,
    output logic                          pkt_valid,
    output logic                          pkt_first,
    output logic                          pkt_last,
    output logic [SLOT_W-1:0]             cur_slot,
    output logic [BYTE_W-1:0]             byte_idx
);

    localparam int PKT_BYTES = HDR_BYTES + 4 * PAYLOAD_WORDS;
    localparam logic [BYTE_W-1:0] LAST_IDX = BYTE_W'(PKT_BYTES - 1);
    localparam logic [BYTE_W-1:0] HDR_LAST = BYTE_W'(HDR_BYTES - 1);

    tx_state_e                    state_q, state_d;
    logic [NUM_SLOTS-1:0][1:0]    mode_q, mode_d;
    logic [NUM_SLOTS-1:0]         pend_q, pend_d;
    logic                         def_v_q, def_v_d;
    logic [1:0]                   def_m_q, def_m_d;
    logic [SLOT_W-1:0]            cur_q, sel;
    logic [BYTE_W-1:0]            idx_q;
    logic                         busy, pkt_end, grant, found;

    assign busy    = (state_q != ST_IDLE);
    assign pkt_end = (state_q == ST_BODY) && (idx_q == LAST_IDX);
    assign grant   = (state_q == ST_IDLE) && pkt_gnt && (|pend_q);

    // Lowest-numbered pending slot wins
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (pend_q[s] && !found) begin
                sel   = SLOT_W'(s);
                found = 1'b1;
            end
        end
    end

    // Mode, deferred-write and pending next-state
    always_comb begin
        def_v_d = def_v_q;
        def_m_d = def_m_q;
        if (pkt_end) begin
            def_v_d = 1'b0;
        end else if (cfg_we && busy) begin
            if (cfg_mode[cur_q] != MODE_OFF) begin
                def_v_d = 1'b1;
                def_m_d = cfg_mode[cur_q];
            end else begin
                def_v_d = 1'b0;
            end
        end

        for (int s = 0; s < NUM_SLOTS; s++) begin
            logic       is_cur;
            logic       hit;
            logic [1:0] m;
            is_cur = busy && (cur_q == SLOT_W'(s));
            m      = mode_q[s];
            if (is_cur && pkt_end)
                m = def_v_q ? def_m_q : ((mode_q[s] == MODE_ONCE) ? MODE_OFF : mode_q[s]);
            if (cfg_we && (!is_cur || cfg_mode[s] == MODE_OFF || pkt_end))
                m = cfg_mode[s];
            mode_d[s] = m;

            hit = (field_stb && mode_q[s] == MODE_FIELD) ||
                  (frame_stb && (mode_q[s] == MODE_FRAME || mode_q[s] == MODE_ONCE));
            pend_d[s] = ((pend_q[s] && !(grant && sel == SLOT_W'(s))) || hit) &&
                        (m != MODE_OFF);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= '0;
            pend_q  <= '0;
            def_v_q <= 1'b0;
            def_m_q <= MODE_OFF;
        end else begin
            mode_q  <= mode_d;
            pend_q  <= pend_d;
            def_v_q <= def_v_d;
            def_m_q <= def_m_d;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (grant)                state_d = ST_HEAD;
            ST_HEAD: if (idx_q == HDR_LAST)    state_d = ST_BODY;
            ST_BODY: if (idx_q == LAST_IDX)    state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // Byte counter and active slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            cur_q <= '0;
        end else if (grant) begin
            idx_q <= '0;
            cur_q <= sel;
        end else if (pkt_end) begin
            idx_q <= '0;
        end else if (busy) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        pkt_req   = 1'b0;
        pkt_valid = 1'b0;
        pkt_first = 1'b0;
        pkt_last  = 1'b0;
        unique case (state_q)
            ST_IDLE: pkt_req = |pend_q;
            ST_HEAD: begin
                pkt_valid = 1'b1;
                pkt_first = (idx_q == '0);
            end
            ST_BODY: begin
                pkt_valid = 1'b1;
                pkt_last  = (idx_q == LAST_IDX);
            end
            default: ;
        endcase
        cur_slot = cur_q;
        byte_idx = idx_q;
        cfg_rdata = 32'd0;
        for (int s = 0; s < NUM_SLOTS; s++)
            cfg_rdata[4*s +: 2] = mode_q[s];
    end

    // R3
    first_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pkt_valid) |-> pkt_first);

    // R3
    burst_unbroken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_last) |=> (pkt_valid && !pkt_first));

    // R4
    grant_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_req && pkt_gnt) |=> pkt_first);

    // R12
    req_quiet_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> !pkt_req);

    // R6
    once_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_last && mode_q[cur_q] == MODE_ONCE && !def_v_q && !cfg_we)
        |=> (mode_q[cur_q] == MODE_OFF));

    // R10
    defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_last && cfg_we && cfg_mode[cur_q] != MODE_OFF)
        |=> (mode_q[cur_q] == $past(mode_q[cur_q])));

endmodule

// File: rtl/infoframe_slot_sched.sv
module infoframe_slot_sched
    import ifs_pkg::*;
#(
    parameter int NUM_SLOTS     = 4,
    parameter int PAYLOAD_WORDS = 7,
    parameter int ADDR_W        = 12,
    parameter int CFG_ADDR      = 'h000,
    parameter int SLOT_BASE     = 'h100,
    parameter int SLOT_STRIDE   = 'h40,
    parameter int SLOT_W        = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              field_stb,
    input  logic              frame_stb,
    output logic              pkt_req,
    input  logic              pkt_gnt,
    output logic              pkt_valid,
    output logic              pkt_first,
    output logic              pkt_last,
    output logic [SLOT_W-1:0] pkt_slot,
    output logic [7:0]        pkt_byte
);

    localparam int PKT_BYTES = HDR_BYTES + 4 * PAYLOAD_WORDS;
    localparam int BYTE_W    = $clog2(PKT_BYTES);

    logic                                          cfg_hit;
    logic [NUM_SLOTS-1:0][1:0]                     cfg_mode;
    logic [31:0]                                   cfg_rdata, slot_rdata;
    logic [NUM_SLOTS-1:0][HDR_BITS-1:0]            hdr;
    logic [NUM_SLOTS-1:0][PAYLOAD_WORDS-1:0][31:0] pay;
    logic [BYTE_W-1:0]                             byte_idx;

    assign cfg_hit = (reg_addr == ADDR_W'(CFG_ADDR));

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_mode
        assign cfg_mode[s] = reg_wdata[4*s +: 2];
    end

    assign reg_rdata = cfg_hit ? cfg_rdata : slot_rdata;

    ifs_slot_regs #(
        .NUM_SLOTS(NUM_SLOTS), .PAYLOAD_WORDS(PAYLOAD_WORDS), .ADDR_W(ADDR_W),
        .SLOT_BASE(SLOT_BASE), .SLOT_STRIDE(SLOT_STRIDE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .hdr(hdr), .pay(pay), .rd_data(slot_rdata)
    );

    ifs_sched #(
        .NUM_SLOTS(NUM_SLOTS), .PAYLOAD_WORDS(PAYLOAD_WORDS),
        .SLOT_W(SLOT_W), .BYTE_W(BYTE_W)
    ) u_sched (
        .clk(clk), .rst_n(rst_n), .cfg_we(reg_we && cfg_hit), .cfg_mode(cfg_mode),
        .cfg_rdata(cfg_rdata), .field_stb(field_stb), .frame_stb(frame_stb),
        .pkt_gnt(pkt_gnt), .pkt_req(pkt_req), .pkt_valid(pkt_valid),
        .pkt_first(pkt_first), .pkt_last(pkt_last), .cur_slot(pkt_slot),
        .byte_idx(byte_idx)
    );

    ifs_byte_pick #(
        .NUM_SLOTS(NUM_SLOTS), .PAYLOAD_WORDS(PAYLOAD_WORDS),
        .SLOT_W(SLOT_W), .BYTE_W(BYTE_W)
    ) u_pick (
        .hdr(hdr), .pay(pay), .slot(pkt_slot), .idx(byte_idx), .byte_out(pkt_byte)
    );

endmodule

// File: tb/infoframe_slot_sched_tb.sv
module infoframe_slot_sched_tb;

    localparam int NS = 4;
    localparam int PW = 7;
    localparam logic [11:0] CFG = 12'h000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        field_stb = 1'b0, frame_stb = 1'b0, pkt_gnt = 1'b0;
    logic        pkt_req, pkt_valid, pkt_first, pkt_last;
    logic [1:0]  pkt_slot;
    logic [7:0]  pkt_byte;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] m_hdr [NS];
    logic [31:0] m_pay [NS][PW];

    always #10 clk = ~clk;

    infoframe_slot_sched u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .field_stb(field_stb),
        .frame_stb(frame_stb), .pkt_req(pkt_req), .pkt_gnt(pkt_gnt),
        .pkt_valid(pkt_valid), .pkt_first(pkt_first), .pkt_last(pkt_last),
        .pkt_slot(pkt_slot), .pkt_byte(pkt_byte)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] hdr_addr(input int s);
        return 12'(12'h100 + s * 12'h40);
    endfunction

    function automatic logic [7:0] exp_byte(input int s, input int i);
        int p;
        if (i == 0) return m_hdr[s][7:0];
        if (i == 1) return m_hdr[s][15:8];
        if (i == 2) return {4'b0, m_hdr[s][19:16]};
        p = i - 3;
        return m_pay[s][p / 4][(p % 4) * 8 +: 8];
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse(input bit fld, input bit frm);
        @(negedge clk);
        field_stb = fld; frame_stb = frm;
        @(negedge clk);
        field_stb = 1'b0; frame_stb = 1'b0;
    endtask

    task automatic expect_idle(input string tag);
        bit seen = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (pkt_req || pkt_valid) seen = 1;
        end
        check(!seen, tag, {31'd0, seen}, 32'd0);
    endtask

    task automatic recv_pkt(input int s, input bit stb_at_grant, input string tag);
        for (int k = 0; k < 40 && !pkt_req; k++) @(negedge clk);
        check(pkt_req, {tag, " R4 request present"}, {31'd0, pkt_req}, 32'd1);
        pkt_gnt = 1'b1; frame_stb = stb_at_grant;
        @(negedge clk);
        pkt_gnt = 1'b0; frame_stb = 1'b0;
        for (int i = 0; i < 31; i++) begin
            logic [7:0] e;
            e = exp_byte(s, i);
            check(pkt_valid && pkt_byte == e && pkt_slot == 2'(s) &&
                  pkt_first == (i == 0) && pkt_last == (i == 30),
                  {tag, " R3 packet byte"}, {pkt_valid, pkt_first, pkt_last, 19'd0, pkt_slot, pkt_byte},
                  {3'b100 | {1'b0, (i == 0), (i == 30)}, 19'd0, 2'(s), e});
            check(!pkt_req, {tag, " R12 req low while sending"}, {31'd0, pkt_req}, 32'd0);
            if (i != 30) @(negedge clk);
        end
        @(negedge clk);
        check(!pkt_valid, {tag, " R3 valid ends"}, {31'd0, pkt_valid}, 32'd0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(CFG, d);
        check(d == 0, "R1 config after reset", d, 0);
        check(!pkt_req && !pkt_valid, "R1 outputs after reset", {30'd0, pkt_req, pkt_valid}, 0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        for (int s = 0; s < NS; s++) begin
            m_hdr[s] = 32'hF0F0_0000 | ((13 - s) << 16) | ((2 + s) << 8) | (8'h81 + s);
            wr(hdr_addr(s), m_hdr[s]);
            m_hdr[s] = m_hdr[s] & 32'h000F_FFFF;
            for (int w = 0; w < PW; w++) begin
                m_pay[s][w] = {8'(s * 16 + w), 8'(8'h40 + w), 8'(8'h70 + s), 8'(8'hC0 + s * 8 + w)};
                wr(12'(hdr_addr(s) + 4 + 4 * w), m_pay[s][w]);
            end
        end
        rd(hdr_addr(2), d);
        check(d == m_hdr[2], "R2 header readback masked", d, m_hdr[2]);
        rd(12'(hdr_addr(3) + 4 + 4 * 6), d);
        check(d == m_pay[3][6], "R2 payload readback", d, m_pay[3][6]);
        wr(CFG, 32'h0000_CCCC);
        rd(CFG, d);
        check(d == 0, "R2 upper nibble bits read zero", d, 0);
    endtask

    task automatic t_off;
        logic [31:0] d;
        pulse(1, 1);
        expect_idle("R5 mode off no request");
        wr(CFG, 32'h0000_3000);
        pulse(0, 1);
        check(pkt_req, "R5 frame slot pending", {31'd0, pkt_req}, 1);
        wr(CFG, 32'h0);
        check(!pkt_req, "R5 clearing mode withdraws request", {31'd0, pkt_req}, 0);
        rd(CFG, d);
    endtask

    task automatic t_once;
        logic [31:0] d;
        wr(CFG, 32'h0000_0010);
        pulse(1, 0);
        expect_idle("R6 once ignores field strobe");
        pulse(0, 1);
        recv_pkt(1, 0, "R6 once packet");
        rd(CFG, d);
        check(d == 0, "R6 once mode cleared", d, 0);
        pulse(0, 1);
        expect_idle("R6 no second send");
    endtask

    task automatic t_field_frame;
        wr(CFG, 32'h0000_0002);
        pulse(0, 1);
        expect_idle("R7 field mode ignores frame strobe");
        pulse(1, 0);
        pulse(1, 0);
        recv_pkt(0, 0, "R8 field packet");
        expect_idle("R8 strobes not duplicated");
        wr(CFG, 32'h0000_0300);
        pulse(1, 0);
        expect_idle("R7 frame mode ignores field strobe");
        pulse(0, 1);
        recv_pkt(2, 0, "R7 frame packet");
    endtask

    task automatic t_priority;
        wr(CFG, 32'h0000_3302);
        pulse(1, 1);
        recv_pkt(0, 0, "R9 first slot0");
        recv_pkt(2, 0, "R9 second slot2");
        recv_pkt(3, 0, "R9 third slot3");
        expect_idle("R9 all served");
        wr(CFG, 32'h0);
    endtask

    task automatic t_collide;
        wr(CFG, 32'h0000_0300);
        pulse(0, 1);
        recv_pkt(2, 1, "R11 first");
        recv_pkt(2, 0, "R11 repeat");
        expect_idle("R11 then idle");
        wr(CFG, 32'h0);
    endtask

    task automatic t_defer;
        logic [31:0] d;
        wr(CFG, 32'h0000_0030);
        pulse(0, 1);
        pkt_gnt = 1'b1;
        @(negedge clk);
        pkt_gnt = 1'b0;
        repeat (3) @(negedge clk);
        wr(CFG, 32'h0000_0010);
        rd(CFG, d);
        check(d == 32'h30, "R10 old mode during packet", d, 32'h30);
        for (int k = 0; k < 40 && !pkt_last; k++) @(negedge clk);
        @(negedge clk);
        rd(CFG, d);
        check(d == 32'h10, "R10 new mode after packet", d, 32'h10);
        expect_idle("R10 no pending after switch");
        pulse(0, 1);
        recv_pkt(1, 0, "R10 re-armed once");
        rd(CFG, d);
        check(d == 0, "R10 re-armed once cleared", d, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_off();
        t_once();
        t_field_frame();
        t_priority();
        t_collide();
        t_defer();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule